// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

The block controls a 32-pin general-purpose I/O port through a small register file on a synchronous bus. Each of the sixteen lower pins works as plain GPIO. A lower direction register sets each of those pins to drive or to listen, and a lower data register holds the value the pin drives. Each of the sixteen upper pins can also serve one of three alternate peripheral functions. Two function-select registers pick the function, with a 2-bit field for each pin. While an upper pin is in GPIO function, an upper direction register and an upper data register control it.

Configuration state answers only to the power-on reset. A warm reset (manual or watchdog) clears the data registers and keeps the configuration. A low-power hold (standby or sleep) freezes every register. A per-pin mode-force input returns an upper pin to GPIO without changing what the function-select register holds. A bonding input tells the block whether the upper pins are bonded out. When they are not, the upper pins drive nothing, but their registers still read and write normally. Pad inputs pass through a two-flop synchronizer before any read can see them.

Top module: `gpio_mux_port`

## Requirements
- R1: While `porRstN` is low, `padOe` is all zero. After power-on reset, every register reads 0x0000.
- R2: Lower pin n (0..15) drives `padOe[n]` = lower direction bit n and `padOut[n]` = lower data bit n. A direction bit of 1 makes the pin an output, and 0 makes it an input.
- R3: The function select s of upper pin 16+k decides its drive. With s = 0 the pin is GPIO, and `padOe`/`padOut` follow upper direction bit k and upper data bit k. With s = 1, 2 or 3, `padOut[16+k]` = `altOut[(s-1)*16+k]` and `padOe[16+k]` = `altOe[(s-1)*16+k]`, and the upper direction bit has no effect.
- R4: Pin 16+k takes its select from bits [2k+1:2k] of the register at address 4. Pin 24+k takes its select from bits [2k+1:2k] of the register at address 5.
- R5: With `modeForce[k]` = 1, pin 16+k acts as GPIO whatever its select field holds. The select register keeps its value and reads it back.
- R6: With `hiBonded` = 0, `padOut[31:16]` and `padOe[31:16]` are zero, and the upper registers can still be written and read back.
- R7: `warmRst` = 1 at a clock edge clears both data registers. It leaves the direction and select registers unchanged and blocks any write in that cycle.
- R8: While `lowPower` = 1, bus writes are ignored and every register keeps its contents.
- R9: A data-register read returns, for each pin, the latched data bit if the pin is GPIO with direction 1. Otherwise it returns the pad level after two synchronizer flops. A pad change that comes before two edges have passed is not yet visible.
- R10: The register map is 0 lower data, 1 upper data, 2 lower direction, 3 upper direction, 4 select for pins 23..16, 5 select for pins 31..24. `busRdata` shows the register at `busAddr` one clock edge later, and addresses 6 and 7 read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| warmRst | input | 1 | Warm (manual or watchdog) reset, synchronous, active high |
| lowPower | input | 1 | Standby/sleep hold; freezes all registers |
| hiBonded | input | 1 | 1 when the upper sixteen pins are bonded out |
| modeForce | input | 16 | Per upper pin, forces GPIO function |
| busAddr | input | 3 | Register address |
| busWe | input | 1 | Write enable |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |
| padIn | input | 32 | Pad input levels |
| padOut | output | 32 | Pad output values |
| padOe | output | 32 | Pad output enables |
| altOut | input | 48 | Alternate-function outputs, 16 per function 1..3 |
| altOe | input | 48 | Alternate-function output enables, 16 per function 1..3 |

## Verification
The bench drives a pad change so that it lands exactly on the read pipeline. It expects two stale reads followed by a fresh one. A design with a single synchronizer flop would return the new level one read too early. The bench sets pins with a high upper direction bit into alternate functions and expects the alternate enable to win. A design that let direction leak through, or that picked the wrong field or the wrong alternate slice, would show the wrong `padOe` pattern, and the select in the top field of the second register catches an off-by-eight layout. Warm reset and low-power hold are both followed by read-back of the direction and select registers. A design that cleared configuration on every reset, or that let writes through during the hold, would return the changed values.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  localparam int ADDR_W = 3;

  // Register addresses (decoded by the control module, selected in the datapath)
  localparam logic [ADDR_W-1:0] ADR_DAT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_DAT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_DIR_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DIR_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_SEL_A  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_SEL_B  = 3'd5;

  // Read-source select carried to the datapath
  typedef enum logic [2:0] {
    RD_DAT_LO = 3'd0,
    RD_DAT_HI = 3'd1,
    RD_DIR_LO = 3'd2,
    RD_DIR_HI = 3'd3,
    RD_SEL_A  = 3'd4,
    RD_SEL_B  = 3'd5,
    RD_ZERO   = 3'd7
  } rdSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   wrDatLo;
    logic   wrDatHi;
    logic   wrDirLo;
    logic   wrDirHi;
    logic   wrSelA;
    logic   wrSelB;
    logic   clrData;
    rdSrc_e rdSrc;
  } dpStrobes_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      stageQ <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_mux_pkg::*;
(
  input  logic              warmRst,
  input  logic              lowPower,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output dpStrobes_t        strobes
);

  logic wrOk;

  // Writes are blocked during warm reset and during the low-power hold
  assign wrOk = busWe && !warmRst && !lowPower;

  always_comb begin
    strobes         = '0;
    strobes.rdSrc   = RD_ZERO;
    strobes.clrData = warmRst;
    unique case (busAddr)
      ADR_DAT_LO: begin strobes.wrDatLo = wrOk; strobes.rdSrc = RD_DAT_LO; end
      ADR_DAT_HI: begin strobes.wrDatHi = wrOk; strobes.rdSrc = RD_DAT_HI; end
      ADR_DIR_LO: begin strobes.wrDirLo = wrOk; strobes.rdSrc = RD_DIR_LO; end
      ADR_DIR_HI: begin strobes.wrDirHi = wrOk; strobes.rdSrc = RD_DIR_HI; end
      ADR_SEL_A:  begin strobes.wrSelA  = wrOk; strobes.rdSrc = RD_SEL_A;  end
      ADR_SEL_B:  begin strobes.wrSelB  = wrOk; strobes.rdSrc = RD_SEL_B;  end
      default:    strobes.rdSrc = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_mux_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int SEL_W = 2,
  localparam int NUM_ALT = (1 << SEL_W) - 1,
  localparam int PIN_N   = 2 * REG_W,
  localparam int PER_REG = REG_W / SEL_W
) (
  input  logic                     clk,
  input  logic                     porRstN,
  input  dpStrobes_t               strobes,
  input  logic [REG_W-1:0]         busWdata,
  output logic [REG_W-1:0]         busRdata,
  input  logic [PIN_N-1:0]         padSync,
  input  logic [NUM_ALT*REG_W-1:0] altOut,
  input  logic [NUM_ALT*REG_W-1:0] altOe,
  input  logic [REG_W-1:0]         modeForce,
  input  logic                     hiBonded,
  output logic [PIN_N-1:0]         padOut,
  output logic [PIN_N-1:0]         padOe
);

  // Configuration: cleared by power-on reset only
  logic [REG_W-1:0] dirLo, dirHi, selA, selB;
  // Data: cleared by power-on reset and by warm reset
  logic [REG_W-1:0] datLo, datHi;
  logic [REG_W-1:0] rdLo, rdHi;
  logic [2*REG_W-1:0] selAll;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      dirLo <= '0;
      dirHi <= '0;
      selA  <= '0;
      selB  <= '0;
    end else begin
      if (strobes.wrDirLo) dirLo <= busWdata;
      if (strobes.wrDirHi) dirHi <= busWdata;
      if (strobes.wrSelA)  selA  <= busWdata;
      if (strobes.wrSelB)  selB  <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      datLo <= '0;
      datHi <= '0;
    end else if (strobes.clrData) begin
      datLo <= '0;
      datHi <= '0;
    end else begin
      if (strobes.wrDatLo) datLo <= busWdata;
      if (strobes.wrDatHi) datHi <= busWdata;
    end
  end

  // Lower pins: GPIO only
  for (genvar i = 0; i < REG_W; i++) begin : g_lo
    assign padOut[i] = datLo[i];
    assign padOe[i]  = dirLo[i];
    assign rdLo[i]   = dirLo[i] ? datLo[i] : padSync[i];
  end

  // Upper pins: select fields, first register covers the lower half of them
  assign selAll = {selB, selA};

  for (genvar k = 0; k < REG_W; k++) begin : g_hi
    logic [SEL_W-1:0] fnSel;
    logic             isGpio;
    logic             altO;
    logic             altE;
    logic             pinO;
    logic             pinE;

    assign fnSel  = modeForce[k] ? '0 : selAll[k*SEL_W +: SEL_W];
    assign isGpio = (fnSel == '0);

    always_comb begin
      altO = 1'b0;
      altE = 1'b0;
      for (int a = 1; a <= NUM_ALT; a++) begin
        if (int'(fnSel) == a) begin
          altO = altOut[(a-1)*REG_W + k];
          altE = altOe[(a-1)*REG_W + k];
        end
      end
    end

    assign pinO = isGpio ? datHi[k] : altO;
    assign pinE = isGpio ? dirHi[k] : altE;

    assign padOut[REG_W+k] = hiBonded & pinO;
    assign padOe[REG_W+k]  = hiBonded & pinE;
    assign rdHi[k] = (isGpio && dirHi[k]) ? datHi[k] : padSync[REG_W+k];
  end

  // Registered read port
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      busRdata <= '0;
    end else begin
      unique case (strobes.rdSrc)
        RD_DAT_LO: busRdata <= rdLo;
        RD_DAT_HI: busRdata <= rdHi;
        RD_DIR_LO: busRdata <= dirLo;
        RD_DIR_HI: busRdata <= dirHi;
        RD_SEL_A:  busRdata <= selA;
        RD_SEL_B:  busRdata <= selB;
        default:   busRdata <= '0;
      endcase
    end
  end

  if (PER_REG * 2 != REG_W) begin : g_bad_sel
    $error("select field width must give two select registers for the upper pins");
  end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int SEL_W = 2,
  localparam int NUM_ALT = (1 << SEL_W) - 1,
  localparam int PIN_N   = 2 * REG_W
) (
  input  logic                     clk,
  input  logic                     porRstN,
  input  logic                     warmRst,
  input  logic                     lowPower,
  input  logic                     hiBonded,
  input  logic [REG_W-1:0]         modeForce,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWe,
  input  logic [REG_W-1:0]         busWdata,
  output logic [REG_W-1:0]         busRdata,
  input  logic [PIN_N-1:0]         padIn,
  output logic [PIN_N-1:0]         padOut,
  output logic [PIN_N-1:0]         padOe,
  input  logic [NUM_ALT*REG_W-1:0] altOut,
  input  logic [NUM_ALT*REG_W-1:0] altOe
);

  dpStrobes_t       strobes;
  logic [PIN_N-1:0] padSync;

  gpio_port_ctrl u_ctrl (
    .warmRst  (warmRst),
    .lowPower (lowPower),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .strobes  (strobes)
  );

  gpio_in_sync #(.WIDTH(PIN_N), .STAGES(2)) u_sync (
    .clk     (clk),
    .porRstN (porRstN),
    .asyncIn (padIn),
    .syncOut (padSync)
  );

  gpio_port_datapath #(.REG_W(REG_W), .SEL_W(SEL_W)) u_dp (
    .clk       (clk),
    .porRstN   (porRstN),
    .strobes   (strobes),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padSync   (padSync),
    .altOut    (altOut),
    .altOe     (altOe),
    .modeForce (modeForce),
    .hiBonded  (hiBonded),
    .padOut    (padOut),
    .padOe     (padOe)
  );

endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int REG_W = 16
) (
  input logic               clk,
  input logic               porRstN,
  input logic               warmRst,
  input logic               lowPower,
  input logic               hiBonded,
  input logic [2:0]         busAddr,
  input logic [REG_W-1:0]   busRdata,
  input logic [2*REG_W-1:0] padOut,
  input logic [2*REG_W-1:0] padOe
);

  AST_POR_OE_LOW: assert property (@(posedge clk)
    !porRstN |-> padOe == '0);  // R1

  AST_UNBONDED_QUIET: assert property (@(posedge clk) disable iff (!porRstN)
    !hiBonded |-> (padOe[2*REG_W-1:REG_W] == '0 && padOut[2*REG_W-1:REG_W] == '0));  // R6

  AST_WARM_CLEARS_DATA: assert property (@(posedge clk) disable iff (!porRstN)
    warmRst |=> padOut[REG_W-1:0] == '0);  // R7

  AST_WARM_KEEPS_DIR: assert property (@(posedge clk) disable iff (!porRstN)
    warmRst |=> $stable(padOe[REG_W-1:0]));  // R7

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!porRstN)
    (lowPower && !warmRst) |=> ($stable(padOut[REG_W-1:0]) && $stable(padOe[REG_W-1:0])));  // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!porRstN)
    (busAddr > 3'd5) |=> busRdata == '0);  // R10

endmodule

bind gpio_mux_port gpio_mux_port_chk #(.REG_W(REG_W)) u_chk (
  .clk      (clk),
  .porRstN  (porRstN),
  .warmRst  (warmRst),
  .lowPower (lowPower),
  .hiBonded (hiBonded),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .padOut   (padOut),
  .padOe    (padOe)
);

// File: tb/gpio_mux_port_bench.sv
module gpio_mux_port_bench;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        warmRst = 1'b0;
  logic        lowPower = 1'b0;
  logic        hiBonded = 1'b1;
  logic [15:0] modeForce = '0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [31:0] padIn = 32'hA5A5_3C3C;
  logic [31:0] padOut, padOe;
  logic [47:0] altOut = '0;
  logic [47:0] altOe = '0;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_mux_port u_gpio_mux_port (
    .clk(clk), .porRstN(porRstN), .warmRst(warmRst), .lowPower(lowPower),
    .hiBonded(hiBonded), .modeForce(modeForce), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .altOut(altOut), .altOe(altOe)
  );

  // Scoreboard
  typedef struct { logic [15:0] exp; string tag; } rdItem_t;
  rdItem_t expQ[$];
  logic issue = 1'b0;
  logic toCheck = 1'b0;

  always @(posedge clk) toCheck <= issue;

  always @(negedge clk) begin
    if (toCheck) begin
      rdItem_t it;
      it = expQ.pop_front();
      nChecks++;
      if (busRdata !== it.exp) begin
        nFails++;
        $display("FAIL %s: busRdata=%h expected %h", it.tag, busRdata, it.exp);
      end
    end
  end

  task automatic doRead(input logic [2:0] a, input logic [15:0] e, input string tag);
    rdItem_t it;
    @(negedge clk);
    busAddr = a;
    it.exp = e;
    it.tag = tag;
    expQ.push_back(it);
    issue = 1'b1;
    @(posedge clk);
    #1 issue = 1'b0;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    nChecks++;
    if (act !== e) begin
      nFails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, e);
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(padOe, 32'h0, "R1 padOe in reset");
    porRstN = 1'b1;
    repeat (4) @(negedge clk);
    doRead(3'd2, 16'h0000, "R1 lower dir");
    doRead(3'd3, 16'h0000, "R1 upper dir");
    doRead(3'd4, 16'h0000, "R1 select A");
    doRead(3'd5, 16'h0000, "R1 select B");
    doRead(3'd0, 16'h3C3C, "R9 input pins read pad");

    // R2 lower GPIO
    busWrite(3'd2, 16'h00FF);
    busWrite(3'd0, 16'h1234);
    chk({16'h0, padOe[15:0]}, 32'h00FF, "R2 lower oe");
    chk({16'h0, padOut[15:0]}, 32'h1234, "R2 lower out");
    doRead(3'd2, 16'h00FF, "R10 lower dir at addr 2");
    doRead(3'd0, 16'h3C34, "R9 mixed in/out read");

    // R9 two-flop latency: change pad right before back-to-back reads
    padIn[15:0] = 16'hFFFF;
    doRead(3'd0, 16'h3C34, "R9 stale read 1");
    doRead(3'd0, 16'h3C34, "R9 stale read 2");
    doRead(3'd0, 16'hFF34, "R9 fresh read");

    // R3 upper GPIO then alternates
    busWrite(3'd3, 16'hFFFF);
    busWrite(3'd1, 16'hBEEF);
    chk({16'h0, padOe[31:16]}, 32'hFFFF, "R3 upper gpio oe");
    chk({16'h0, padOut[31:16]}, 32'hBEEF, "R3 upper gpio out");
    altOut = {16'h0004, 16'h0000, 16'h0001};
    altOe  = {16'h0000, 16'hFFFF, 16'h0000};
    busWrite(3'd4, 16'h0039);
    chk({16'h0, padOe[31:16]}, 32'hFFFA, "R3 alternate oe overrides dir");
    chk({16'h0, padOut[31:16]}, 32'hBEED, "R3 alternate out");

    // R4 field of pin 31 in second register
    busWrite(3'd5, 16'hC000);
    chk({16'h0, padOe[31:16]}, 32'h7FFA, "R4 pin31 select field");
    chk({16'h0, padOut[31:16]}, 32'h3EED, "R4 pin31 alt out");

    // R5 mode force
    modeForce = 16'h0007;
    #1;
    chk({16'h0, padOe[31:16]}, 32'h7FFF, "R5 forced gpio oe");
    chk({16'h0, padOut[31:16]}, 32'h3EEF, "R5 forced gpio out");
    doRead(3'd4, 16'h0039, "R5 select kept");
    modeForce = 16'h0000;

    // R6 unbonded
    hiBonded = 1'b0;
    #1;
    chk(padOe[31:16], 16'h0, "R6 unbonded oe");
    chk(padOut[31:16], 16'h0, "R6 unbonded out");
    busWrite(3'd3, 16'h1234);
    doRead(3'd3, 16'h1234, "R6 upper dir rw while unbonded");
    busWrite(3'd3, 16'hFFFF);
    hiBonded = 1'b1;

    // R8 low-power hold
    @(negedge clk);
    lowPower = 1'b1;
    busWrite(3'd2, 16'hFFFF);
    busWrite(3'd0, 16'h0000);
    chk({16'h0, padOut[15:0]}, 32'h1234, "R8 data held");
    doRead(3'd2, 16'h00FF, "R8 dir held");
    @(negedge clk);
    lowPower = 1'b0;

    // R7 warm reset
    @(negedge clk);
    warmRst = 1'b1;
    @(negedge clk);
    warmRst = 1'b0;
    chk({16'h0, padOut[15:0]}, 32'h0, "R7 lower data cleared");
    chk({16'h0, padOe[15:0]}, 32'h00FF, "R7 lower dir kept");
    doRead(3'd2, 16'h00FF, "R7 dir reg kept");
    doRead(3'd4, 16'h0039, "R7 select A kept");
    doRead(3'd5, 16'hC000, "R7 select B kept");
    doRead(3'd1, 16'h8005, "R7 R9 upper data after warm reset");
    doRead(3'd0, 16'hFF00, "R7 R9 lower data after warm reset");

    // R10 unmapped
    doRead(3'd6, 16'h0000, "R10 addr 6");
    doRead(3'd7, 16'h0000, "R10 addr 7");
    doRead(3'd3, 16'hFFFF, "R10 upper dir at addr 3");

    // R1 power-on reset again
    drain();
    porRstN = 1'b0;
    @(negedge clk);
    chk(padOe, 32'h0, "R1 padOe after second reset");
    porRstN = 1'b1;
    doRead(3'd4, 16'h0000, "R1 select cleared by power-on");
    doRead(3'd2, 16'h0000, "R1 dir cleared by power-on");
    drain();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule